// File: doc/BRIEF.md
# Modem Control Register with Diagnostic Loopback

This block holds the byte-wide modem control register of a serial port. A CPU writes it with a single-cycle strobe and reads it back. The stored bits drive the two active-low handshake pins, which are data-terminal-ready and request-to-send. The register also holds a spare flag with no pin and an interrupt gate. The gate decides whether the port's interrupt line is driven or left floating. The floating state is shown as an output-enable signal, so the block needs no tristate cell.

A fifth bit selects a diagnostic loopback mode. In that mode the transmit pin is held at mark and both handshake pins are forced inactive high. The serial stream from the transmitter goes straight into the receiver input, and the external receive pin is ignored. The four modem status bits seen by the rest of the port are then taken from the low four control bits instead of the external modem inputs. Baud timing, shifting, FIFOs and the other port registers live elsewhere.

Top module: `modem_ctl_loop`

## Requirements
- R1: After a synchronous active-low reset the register reads 0x00. Both handshake pins are high and the interrupt output enable is low.
- R2: Outside loopback, `dtr_pin_n` is the inverse of control bit 0 and `rts_pin_n` is the inverse of control bit 1.
- R3: Control bit 2 is stored and read back. It has no effect on any pin.
- R4: `irq_oe` equals control bit 3. `irq_out` follows `irq_raw` while bit 3 is 1 and is 0 while bit 3 is 0. This holds in both modes.
- R5: Read-back bits 7..5 are always 0, and writes to them are ignored.
- R6: Outside loopback, `tx_pin` follows `ser_tx` and `rx_ser` follows `rx_pin`. Each status output (`stat_cts`, `stat_dsr`, `stat_ri`, `stat_dcd`) is the inverse of its active-low external input.
- R7: With control bit 4 set, `tx_pin` is 1, both handshake pins are 1, and `rx_ser` follows `ser_tx`. `rx_pin` has no effect.
- R8: With control bit 4 set, the status outputs take control bits in true sense: `stat_dsr` from bit 0, `stat_cts` from bit 1, `stat_ri` from bit 2 and `stat_dcd` from bit 3. The external modem inputs have no effect.
- R9: In a cycle without `cpu_wr`, the register keeps its value.
- R10: A write with `cpu_wr` high is visible on `cpu_rdata` and on all outputs from the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read-back value |
| ser_tx | input | 1 | Serial bit from the transmit shifter |
| rx_pin | input | 1 | External receive line |
| ext_cts_n | input | 1 | External clear-to-send, active low |
| ext_dsr_n | input | 1 | External data-set-ready, active low |
| ext_ri_n | input | 1 | External ring indicator, active low |
| ext_dcd_n | input | 1 | External carrier detect, active low |
| irq_raw | input | 1 | Combined interrupt request of the port |
| tx_pin | output | 1 | Transmit line pin |
| dtr_pin_n | output | 1 | Data-terminal-ready pin, active low |
| rts_pin_n | output | 1 | Request-to-send pin, active low |
| rx_ser | output | 1 | Serial input to the receive shifter |
| stat_cts | output | 1 | Effective clear-to-send status, active high |
| stat_dsr | output | 1 | Effective data-set-ready status, active high |
| stat_ri | output | 1 | Effective ring status, active high |
| stat_dcd | output | 1 | Effective carrier status, active high |
| irq_out | output | 1 | Gated interrupt value |
| irq_oe | output | 1 | Interrupt output enable; 0 means high impedance |

## Verification
The hardest situation to reach is one where the external inputs disagree with the looped-back values at the same moment the mode bit changes. A wrong source selection or a swapped status mapping only shows up in that case. The stimulus randomises the external modem lines, the receive pin and the transmit bit on every cycle. It also writes random bytes about half the time, so loopback switches on and off often and happens while the control bits hold every combination. A behavioural reference register in the bench predicts every output on every cycle.

// File: rtl/mcl_pkg.sv
// Package: shared field layout of the modem control register.
// Assumes the five stored bits sit at positions 4..0 of the CPU byte.
package mcl_pkg;

    // Stored control fields, MSB first so the packed order matches bits 4..0.
    typedef struct packed {
        logic loop_en;   // bit 4: diagnostic loopback
        logic irq_gate;  // bit 3: interrupt output enable
        logic spare;     // bit 2: storage only
        logic rts;       // bit 1: request to send
        logic dtr;       // bit 0: data terminal ready
    } mcr_t;

    localparam int unsigned MCR_BITS   = $bits(mcr_t);
    localparam int unsigned MODEM_LINES = 4;

    // Status vector order used inside the block.
    localparam int unsigned ST_CTS = 0;
    localparam int unsigned ST_DSR = 1;
    localparam int unsigned ST_RI  = 2;
    localparam int unsigned ST_DCD = 3;

endpackage

// File: rtl/mcl_ctrl_reg.sv
// Module: CPU-writable control register with zero-padded read-back.
// Assumes DATA_W >= CTRL_BITS; the bits above CTRL_BITS are discarded on write.
module mcl_ctrl_reg #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CTRL_BITS = 5,
    parameter logic [CTRL_BITS-1:0] RESET_VAL = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wdata,
    output logic [CTRL_BITS-1:0] ctrl,
    output logic [DATA_W-1:0]    rdata
);
    localparam int unsigned PAD_W = DATA_W - CTRL_BITS;

    logic [CTRL_BITS-1:0] ctrl_q;

    // Capture the low bits of the write data on a strobe; reset to RESET_VAL.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= RESET_VAL;
        else if (wr_en)
            ctrl_q <= wdata[CTRL_BITS-1:0];
    end

    assign ctrl = ctrl_q;

    // Read-back: unused upper bits are fixed at zero.
    generate
        if (PAD_W > 0) begin : g_pad
            assign rdata = {{PAD_W{1'b0}}, ctrl_q};
        end else begin : g_nopad
            assign rdata = ctrl_q;
        end
    endgenerate
endmodule

// File: rtl/mcl_pin_mux.sv
// Module: drives the transmit and handshake pins and gates the interrupt.
// Assumes the control fields come straight from the register, with no extra delay.
module mcl_pin_mux
    import mcl_pkg::*;
(
    input  mcr_t ctrl,
    input  logic ser_tx,
    input  logic irq_raw,
    output logic tx_pin,
    output logic dtr_pin_n,
    output logic rts_pin_n,
    output logic irq_out,
    output logic irq_oe
);
    // Pin drive: loopback parks everything at its idle-high level.
    always_comb begin
        if (ctrl.loop_en) begin
            tx_pin    = 1'b1;
            dtr_pin_n = 1'b1;
            rts_pin_n = 1'b1;
        end else begin
            tx_pin    = ser_tx;
            dtr_pin_n = ~ctrl.dtr;
            rts_pin_n = ~ctrl.rts;
        end
    end

    // Interrupt gate: the enable stands in for the tristate; the value is quiet when disabled.
    always_comb begin
        irq_oe  = ctrl.irq_gate;
        irq_out = ctrl.irq_gate & irq_raw;
    end
endmodule

// File: rtl/mcl_status_mux.sv
// Module: selects the receive serial source and the effective modem status.
// Assumes the external status inputs are active low and the looped values active high.
module mcl_status_mux #(
    parameter int unsigned LINES = 4
) (
    input  logic             loop_en,
    input  logic [LINES-1:0] ext_n,
    input  logic [LINES-1:0] looped,
    input  logic             rx_pin,
    input  logic             ser_tx,
    output logic [LINES-1:0] status,
    output logic             rx_ser
);
    // One selector per modem status line.
    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            assign status[i] = loop_en ? looped[i] : ~ext_n[i];
        end
    endgenerate

    // Receive path: in loopback the transmitter stream replaces the pin.
    always_comb rx_ser = loop_en ? ser_tx : rx_pin;
endmodule

// File: rtl/modem_ctl_loop.sv
// Module: top of the modem control register with diagnostic loopback.
// Assumes a single clock domain. The external modem inputs are already synchronised.
module modem_ctl_loop
    import mcl_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              ser_tx,
    input  logic              rx_pin,
    input  logic              ext_cts_n,
    input  logic              ext_dsr_n,
    input  logic              ext_ri_n,
    input  logic              ext_dcd_n,
    input  logic              irq_raw,
    output logic              tx_pin,
    output logic              dtr_pin_n,
    output logic              rts_pin_n,
    output logic              rx_ser,
    output logic              stat_cts,
    output logic              stat_dsr,
    output logic              stat_ri,
    output logic              stat_dcd,
    output logic              irq_out,
    output logic              irq_oe
);
    localparam int unsigned CTRL_BITS = MCR_BITS;

    logic [CTRL_BITS-1:0]   ctrl_bits;
    mcr_t                   ctrl;
    logic [MODEM_LINES-1:0] ext_n;
    logic [MODEM_LINES-1:0] looped;
    logic [MODEM_LINES-1:0] status;

    mcl_ctrl_reg #(
        .DATA_W    (DATA_W),
        .CTRL_BITS (CTRL_BITS),
        .RESET_VAL ('0)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cpu_wr),
        .wdata (cpu_wdata),
        .ctrl  (ctrl_bits),
        .rdata (cpu_rdata)
    );

    assign ctrl = mcr_t'(ctrl_bits);

    mcl_pin_mux u_pins (
        .ctrl      (ctrl),
        .ser_tx    (ser_tx),
        .irq_raw   (irq_raw),
        .tx_pin    (tx_pin),
        .dtr_pin_n (dtr_pin_n),
        .rts_pin_n (rts_pin_n),
        .irq_out   (irq_out),
        .irq_oe    (irq_oe)
    );

    // Pack external inputs and loopback sources in the shared line order.
    always_comb begin
        ext_n[ST_CTS]  = ext_cts_n;
        ext_n[ST_DSR]  = ext_dsr_n;
        ext_n[ST_RI]   = ext_ri_n;
        ext_n[ST_DCD]  = ext_dcd_n;
        looped[ST_CTS] = ctrl.rts;
        looped[ST_DSR] = ctrl.dtr;
        looped[ST_RI]  = ctrl.spare;
        looped[ST_DCD] = ctrl.irq_gate;
    end

    mcl_status_mux #(
        .LINES (MODEM_LINES)
    ) u_stat (
        .loop_en (ctrl.loop_en),
        .ext_n   (ext_n),
        .looped  (looped),
        .rx_pin  (rx_pin),
        .ser_tx  (ser_tx),
        .status  (status),
        .rx_ser  (rx_ser)
    );

    assign stat_cts = status[ST_CTS];
    assign stat_dsr = status[ST_DSR];
    assign stat_ri  = status[ST_RI];
    assign stat_dcd = status[ST_DCD];
endmodule

// File: rtl/modem_ctl_loop_chk.sv
// Module: property checker for modem_ctl_loop, attached by bind.
// Assumes it sees only the top-level ports.
module modem_ctl_loop_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              ser_tx,
    input logic              tx_pin,
    input logic              dtr_pin_n,
    input logic              rts_pin_n,
    input logic              rx_ser,
    input logic              rx_pin,
    input logic              stat_dsr,
    input logic              stat_cts,
    input logic              irq_raw,
    input logic              irq_out,
    input logic              irq_oe
);
    // R1: a reset cycle leaves the register cleared.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (cpu_rdata == '0));

    // R2: handshake pins mirror the read-back value, inverted, outside loopback.
    a_r2_dtr_rts_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rdata[4] |-> (dtr_pin_n == !cpu_rdata[0] && rts_pin_n == !cpu_rdata[1]));

    // R4: interrupt enable tracks the gate bit.
    a_r4_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oe == cpu_rdata[3]) && (irq_oe || !irq_out) && (!irq_oe || irq_out == irq_raw));

    // R5: upper read-back bits stay zero.
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[DATA_W-1:5] == '0);

    // R7: loopback parks the pins and routes the transmit stream inward.
    a_r7_loop_pins: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[4] |-> (tx_pin && dtr_pin_n && rts_pin_n && rx_ser == ser_tx));

    // R6: normal mode passes the serial lines straight through.
    a_r6_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rdata[4] |-> (tx_pin == ser_tx && rx_ser == rx_pin));

    // R8: looped status copies the handshake bits.
    a_r8_loop_status: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[4] |-> (stat_dsr == cpu_rdata[0] && stat_cts == cpu_rdata[1]));

    // R9: no strobe, no change.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> $stable(cpu_rdata));

    // R10: a strobed write appears on the next edge.
    a_r10_write_seen: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> (cpu_rdata[4:0] == $past(cpu_wdata[4:0])));
endmodule

bind modem_ctl_loop modem_ctl_loop_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .ser_tx    (ser_tx),
    .tx_pin    (tx_pin),
    .dtr_pin_n (dtr_pin_n),
    .rts_pin_n (rts_pin_n),
    .rx_ser    (rx_ser),
    .rx_pin    (rx_pin),
    .stat_dsr  (stat_dsr),
    .stat_cts  (stat_cts),
    .irq_raw   (irq_raw),
    .irq_out   (irq_out),
    .irq_oe    (irq_oe)
);

// File: tb/modem_ctl_loop_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference register compared with every output on every cycle.
module modem_ctl_loop_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       ser_tx = 1'b1, rx_pin = 1'b1;
    logic       ext_cts_n = 1'b1, ext_dsr_n = 1'b1, ext_ri_n = 1'b1, ext_dcd_n = 1'b1;
    logic       irq_raw = 1'b0;
    logic       tx_pin, dtr_pin_n, rts_pin_n, rx_ser;
    logic       stat_cts, stat_dsr, stat_ri, stat_dcd, irq_out, irq_oe;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    logic [7:0] model = '0;

    always #2 clk = ~clk;

    modem_ctl_loop u_modem_ctl_loop (.*);

    // Reference register: plain behavioural update of the requirement text.
    always @(posedge clk) begin
        if (!rst_n)      model <= 8'h00;
        else if (cpu_wr) model <= cpu_wdata & 8'h1F;
    end

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the reference model.
    task automatic check_all();
        bit lp;
        lp = model[4];
        cmp("R10 R5 R3 readback", cpu_rdata, model);
        cmp(lp ? "R7 tx mark" : "R6 tx pass", {7'b0, tx_pin}, {7'b0, lp ? 1'b1 : ser_tx});
        cmp(lp ? "R7 rx loop" : "R6 rx pass", {7'b0, rx_ser}, {7'b0, lp ? ser_tx : rx_pin});
        cmp(lp ? "R7 dtr idle" : "R2 dtr", {7'b0, dtr_pin_n}, {7'b0, lp ? 1'b1 : !model[0]});
        cmp(lp ? "R7 rts idle" : "R2 rts", {7'b0, rts_pin_n}, {7'b0, lp ? 1'b1 : !model[1]});
        cmp(lp ? "R8 status" : "R6 status", {4'b0, stat_dcd, stat_ri, stat_dsr, stat_cts},
            lp ? {4'b0, model[3], model[2], model[0], model[1]}
               : {4'b0, !ext_dcd_n, !ext_ri_n, !ext_dsr_n, !ext_cts_n});
        cmp("R4 irq", {6'b0, irq_oe, irq_out}, {6'b0, model[3], model[3] & irq_raw});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Drive one cycle at the falling edge, then compare after settling.
    task automatic step(input bit wr, input logic [7:0] d, input bit rnd_io);
        @(negedge clk);
        cpu_wr    = wr;
        cpu_wdata = d;
        if (rnd_io) begin
            ser_tx    = 1'($urandom);
            rx_pin    = 1'($urandom);
            ext_cts_n = 1'($urandom);
            ext_dsr_n = 1'($urandom);
            ext_ri_n  = 1'($urandom);
            ext_dcd_n = 1'($urandom);
            irq_raw   = 1'($urandom);
        end
        #1 check_all();
    endtask

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        #1;
        cmp("R1 rdata", cpu_rdata, 8'h00);
        cmp("R1 pins", {6'b0, dtr_pin_n, rts_pin_n}, 8'h03);
        cmp("R1 irq_oe", {7'b0, irq_oe}, 8'h00);
        @(negedge clk) rst_n = 1'b1;
        // R2 handshake asserted; R5 upper bits dropped; R3 spare bit alone.
        step(1'b1, 8'hE3, 1'b1);
        step(1'b0, 8'h00, 1'b1);
        step(1'b1, 8'hE4, 1'b1);
        step(1'b0, 8'hFF, 1'b1);   // R9: data without strobe
        // R4 gate enabled, then R7/R8 loopback with all bits set.
        step(1'b1, 8'h08, 1'b1);
        step(1'b1, 8'h1F, 1'b1);
        step(1'b1, 8'h10, 1'b1);
        step(1'b0, 8'h0F, 1'b1);
        // Random traffic: frequent mode flips with random external inputs.
        for (int i = 0; i < 3000; i++)
            step(1'($urandom), 8'($urandom), 1'b1);
        // R1: reset again from a non-zero state.
        step(1'b1, 8'h1B, 1'b1);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) #1 check_all();
        cmp("R1 re-reset", cpu_rdata, 8'h00);
        finish_run();
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end
endmodule